// File: doc/BRIEF.md
# Dual-Style Bit-Change Detector

This block watches a one-bit serial stream. It raises a flag whenever the two most recent bits differ, which means the pattern 01 or 10 has just appeared. The same detection is built twice inside one module, and the two copies run side by side on the same input.

The first copy is a five-state machine whose flag is decoded from the registered state alone. It therefore reports a change in the cycle after the clock edge that captured the second bit of the pair. The second copy is a three-state machine whose flag combines the stored state with the live input. It reports the change in the same cycle that the new bit is presented.

A synchronous reset returns both machines to their start state. A designer can compare the two flags to see the one-cycle timing difference between the two styles directly.

Top module: `seq_change_detector`

## Requirements
- R1: While `rst` is high at a rising edge, both machines return to their start state whatever `din` is. `mealy_flag` is 0 during any cycle in which `rst` is high. `moore_flag` is 0 in the cycle after that edge.
- R2: Once at least two bits have been sampled since reset, `moore_flag` is 1 exactly when the last two sampled bits differ.
- R3: With exactly one bit sampled since reset, `moore_flag` is 0.
- R4: Once at least one bit has been sampled since reset and `rst` is low, `mealy_flag` is 1 exactly when the present `din` differs from the last sampled bit.
- R5: With no bit sampled since reset, `mealy_flag` is 0 for either value of `din`.
- R6: Outside reset, `moore_flag` in each cycle equals the value `mealy_flag` had in the cycle before, provided that previous cycle was not a reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial input bit, sampled each rising edge |
| moore_flag | output | 1 | Change flag decoded from registered state only |
| mealy_flag | output | 1 | Change flag from state and the present input |

## Verification
`mealy_flag` is combinational, so it is due in the same cycle that `din` is driven. The bench drives `din` on the falling edge and compares the flag 5 ns later, before the next rising edge. `moore_flag` depends on a bit only after the rising edge that captures that bit, so each Moore check compares against bits from edges that have already occurred. The bench runs every 8-bit sequence after a reset and inserts resets in the middle of streams with both input values. At each step it also compares `moore_flag` with the Mealy flag observed one cycle earlier.

// File: rtl/seq_change_detector.sv
module seq_change_detector (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic moore_flag,
  output logic mealy_flag
);

  typedef enum logic [2:0] {
    MO_START  = 3'd0,
    MO_LOW    = 3'd1,
    MO_HIGH   = 3'd2,
    MO_ROSE   = 3'd3,
    MO_FELL   = 3'd4
  } moore_st_t;

  typedef enum logic [1:0] {
    ME_START = 2'd0,
    ME_LOW   = 2'd1,
    ME_HIGH  = 2'd2
  } mealy_st_t;

  moore_st_t mo_q, mo_d;
  mealy_st_t me_q, me_d;

  always_comb begin
    case (mo_q)
      MO_START: mo_d = din ? MO_HIGH : MO_LOW;
      MO_LOW:   mo_d = din ? MO_ROSE : MO_LOW;
      MO_HIGH:  mo_d = din ? MO_HIGH : MO_FELL;
      MO_ROSE:  mo_d = din ? MO_HIGH : MO_FELL;
      MO_FELL:  mo_d = din ? MO_ROSE : MO_LOW;
      default:  mo_d = MO_START;
    endcase
  end

  always_comb begin
    case (me_q)
      ME_START: me_d = din ? ME_HIGH : ME_LOW;
      ME_LOW:   me_d = din ? ME_HIGH : ME_LOW;
      ME_HIGH:  me_d = din ? ME_HIGH : ME_LOW;
      default:  me_d = ME_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mo_q <= MO_START;
      me_q <= ME_START;
    end else begin
      mo_q <= mo_d;
      me_q <= me_d;
    end
  end

  assign moore_flag = (mo_q == MO_ROSE) || (mo_q == MO_FELL);
  assign mealy_flag = !rst && (((me_q == ME_LOW) && din) || ((me_q == ME_HIGH) && !din));

endmodule

// File: rtl/seq_change_detector_chk.sv
module seq_change_detector_chk (
  input logic clk,
  input logic rst,
  input logic din,
  input logic moore_flag,
  input logic mealy_flag
);

  AST_RST_MEALY_LOW: assert property (@(posedge clk) rst |-> !mealy_flag); // R1
  AST_RST_MOORE_LOW: assert property (@(posedge clk) rst |=> !moore_flag); // R1
  AST_MOORE_PAIR_DIFF: assert property (@(posedge clk) disable iff (rst)
    moore_flag |-> ($past(din) != $past(din, 2))); // R2
  AST_MEALY_LIVE_DIFF: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mealy_flag) |-> (din != $past(din))); // R4
  AST_MOORE_LAGS_MEALY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (moore_flag == $past(mealy_flag))); // R6

endmodule

bind seq_change_detector seq_change_detector_chk u_chk (.*);

// File: tb/tb_seq_change_detector.sv
module tb_seq_change_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic moore_flag, mealy_flag;

  int checks = 0;
  int errors = 0;
  int nsamp = 0;
  logic last_bit = 1'b0;
  logic older_bit = 1'b0;
  logic prev_mealy = 1'b0;
  logic prev_rst = 1'b1;

  always #10 clk = ~clk;

  seq_change_detector dut (
    .clk(clk), .rst(rst), .din(din),
    .moore_flag(moore_flag), .mealy_flag(mealy_flag)
  );

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic d);
    logic exp_me, exp_mo;
    string tme, tmo;
    @(negedge clk);
    rst = r;
    din = d;
    #5;
    exp_me = !r && (nsamp >= 1) && (d != last_bit);
    tme = r ? "R1" : (nsamp == 0 ? "R5" : "R4");
    check(mealy_flag, exp_me, tme);
    exp_mo = (nsamp >= 2) && (last_bit != older_bit);
    tmo = (nsamp == 0) ? "R1" : (nsamp == 1 ? "R3" : "R2");
    check(moore_flag, exp_mo, tmo);
    if (!prev_rst && !r) check(moore_flag, prev_mealy, "R6");
    prev_mealy = mealy_flag;
    prev_rst = r;
    @(posedge clk);
    if (r) nsamp = 0;
    else begin
      older_bit = last_bit;
      last_bit = d;
      nsamp++;
    end
  endtask

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int pat = 0; pat < 256; pat++) begin
      step(1'b1, pat[0]);
      for (int i = 0; i < 8; i++) step(1'b0, pat[i]);
    end
    for (int k = 0; k < 16; k++) begin
      step(1'b0, k[0]);
      step(1'b0, k[1]);
      step(1'b0, k[2]);
      step(1'b1, k[3]);
      step(1'b0, k[1]);
      step(1'b0, k[0]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule